// File: doc/BRIEF.md
# Fractional Edge Clock Divider

This block takes one fast input clock and produces one slower clock. The ratio is set at build time to either 2 or 3.5 input clock periods per output period. It is intended to generate the slow side of a DDR-style I/O clock pair, where data is moved between a fast edge-clock domain and a slower core domain.

The 3.5 ratio needs output edges on both input clock edges. A rising-edge stage and a falling-edge stage each own one toggle flop, and the output is the XOR of the two. Each toggle flop changes only when the output must change on its own edge, so only one of them moves at a time.

A word-align request input lets a receiver shift the output by one input cycle. This lets the receiver try each output phase in turn until incoming words line up. An active-high asynchronous reset forces the output low at once. An optional second reset input can be merged into the block's reset by a parameter.

Top module: `frac_edge_clk_div`

## Requirements
- R1: With `DIV_HALVES` = 4 (ratio 2), the output period is two input cycles. The output is high for one full input cycle and low for the next, and it changes only on rising input edges.
- R2: With `DIV_HALVES` = 7 (ratio 3.5), each output period is seven input half-cycles: high for four, then low for three. Successive output edges fall alternately on rising and on falling input edges.
- R3: While `rst` is high, `clk_out` is low. Asserting `rst` between clock edges drives `clk_out` low without waiting for an input edge.
- R4: After reset is released, `clk_out` rises on the first rising input edge and then follows the pattern of R1 or R2, starting at the beginning of a high phase.
- R5: `align_in` passes through two rising-edge synchronizer flops and an edge detector. If `align_in` goes high between rising edges k and k+1, one slip occupies the input cycle that starts at rising edge k+3. Keeping `align_in` high longer causes no further slips. Each new low-to-high transition causes exactly one more slip.
- R6: During a slipped input cycle, both halves of `clk_out` keep the level it had at the end of the previous input cycle. The pattern then resumes where it left off. The output period that contains the slip is therefore exactly two half-cycles longer, and the slip adds no extra output edges.
- R7: With `USE_CHIP_RST` = 1, `chip_rst` acts exactly like `rst`. With `USE_CHIP_RST` = 0, `chip_rst` has no effect on `clk_out`.
- R8: When no parameter is overridden, the block divides by 2 (`DIV_HALVES` = 4) and ignores `chip_rst` (`USE_CHIP_RST` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; both of its edges are used |
| rst | input | 1 | Active-high asynchronous reset; holds the output low |
| chip_rst | input | 1 | Optional second reset; used only when `USE_CHIP_RST` = 1 |
| align_in | input | 1 | Word-align request; each rising transition slips the output by one input cycle |
| clk_out | output | 1 | Divided clock |

## Verification
Two instances run side by side: one with default parameters (ratio 2, second reset ignored) and one with ratio 3.5 and the second reset merged in. Both are compared every half-cycle against a behavioural model that tracks the output level in input half-cycles.

Align pulses are issued at seven successive phase offsets. This exposes a slip that lands on a high half, a low half, or a half-cycle toggle boundary, and separates a correct one-cycle stretch from a lost or doubled edge. A long held align level tells edge detection apart from level sensing. Mid-cycle resets, and a pulse on the optional reset, tell apart asynchronous clearing, correct restart phase, and correct gating of the second reset per instance.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  // Output high time in half-cycles for a period of `halves` half-cycles.
  function automatic int high_halves(input int halves);
    return (halves + 1) / 2;
  endfunction

  // Bits needed to hold a phase index plus a step of two.
  function automatic int phase_bits(input int halves);
    return $clog2(halves + 2);
  endfunction
endpackage

// File: rtl/fcd_align_sync.sv
module fcd_align_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic align_in,
  output logic slip_req
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], align_in};
  end

  assign slip_req = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R5: a request is a single-cycle pulse, however long align_in stays high
  p_single_slip_r5: assert property (@(posedge clk) disable iff (rst)
    slip_req |=> !slip_req);
endmodule

// File: rtl/fcd_rise_stage.sv
module fcd_rise_stage #(
  parameter int HALVES = 4,
  parameter int HIGH   = 2,
  parameter int PW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slip_req,
  output logic [PW-1:0] ph_q,
  output logic          held_q,
  output logic          tog_q
);
  localparam logic [PW:0]   LIM  = (PW+1)'(HALVES);
  localparam logic [PW-1:0] HI_P = PW'(HIGH);
  localparam logic [PW-1:0] RST_P = PW'(HALVES - 2);

  logic [PW:0]   sum;
  logic [PW-1:0] nxt;
  logic          edge_here;

  always_comb begin
    sum = {1'b0, ph_q} + (PW+1)'(2);
    if (sum >= LIM) nxt = PW'(sum - LIM);
    else            nxt = PW'(sum);
    edge_here = (nxt == '0) || (nxt == HI_P);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ph_q   <= RST_P;
      held_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      held_q <= slip_req;
      if (!slip_req) begin
        ph_q <= nxt;
        if (edge_here) tog_q <= ~tog_q;
      end
    end
  end
endmodule

// File: rtl/fcd_fall_stage.sv
module fcd_fall_stage #(
  parameter int HALVES = 7,
  parameter int HIGH   = 4,
  parameter int PW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] ph,
  input  logic          held,
  output logic          tog_q
);
  localparam logic [PW-1:0] LAST = PW'(HALVES - 1);
  localparam logic [PW-1:0] HI_P = PW'(HIGH);

  logic [PW-1:0] fph;
  logic          edge_here;

  always_comb begin
    fph       = (ph == LAST) ? '0 : ph + PW'(1);
    edge_here = (fph == '0) || (fph == HI_P);
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst)                     tog_q <= 1'b0;
    else if (!held && edge_here) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/frac_edge_clk_div.sv
module frac_edge_clk_div #(
  parameter int DIV_HALVES   = 4,
  parameter bit USE_CHIP_RST = 1'b0
) (
  input  logic clk_in,
  input  logic rst,
  input  logic chip_rst,
  input  logic align_in,
  output logic clk_out
);
  import fcd_pkg::*;

  localparam int HIGH = high_halves(DIV_HALVES);
  localparam int PW   = phase_bits(DIV_HALVES);

  logic          rst_any;
  logic          slip_req;
  logic [PW-1:0] ph;
  logic          held_q;
  logic          tog_r;
  logic          tog_f;

  generate
    if (USE_CHIP_RST) begin : g_chip_rst
      assign rst_any = rst | chip_rst;
    end else begin : g_no_chip_rst
      logic unused_chip_rst;
      assign unused_chip_rst = chip_rst;
      assign rst_any = rst;
    end
  endgenerate

  fcd_align_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk_in), .rst(rst_any), .align_in(align_in), .slip_req(slip_req)
  );

  fcd_rise_stage #(.HALVES(DIV_HALVES), .HIGH(HIGH), .PW(PW)) u_rise (
    .clk(clk_in), .rst(rst_any), .slip_req(slip_req),
    .ph_q(ph), .held_q(held_q), .tog_q(tog_r)
  );

  generate
    if (DIV_HALVES % 2 == 1) begin : g_fall
      fcd_fall_stage #(.HALVES(DIV_HALVES), .HIGH(HIGH), .PW(PW)) u_fall (
        .clk(clk_in), .rst(rst_any), .ph(ph), .held(held_q), .tog_q(tog_f)
      );
    end else begin : g_no_fall
      logic [PW-1:0] unused_ph;
      assign unused_ph = ph;
      assign tog_f = 1'b0;
    end
  endgenerate

  // Only one toggle flop moves at any edge, so the XOR cannot glitch.
  assign clk_out = tog_r ^ tog_f;

  // R3: output is low whenever reset is active
  p_rst_low_r3: assert property (@(posedge clk_in) rst_any |-> !clk_out);

  // R6: across a slipped cycle the output keeps its level
  p_hold_freezes_out_r6: assert property (@(posedge clk_in) disable iff (rst_any)
    held_q |-> $stable(clk_out));

  generate
    if (DIV_HALVES == 4) begin : g_chk_div2
      // R1: without a slip the ratio-2 output alternates every input cycle
      p_div2_alternate_r1: assert property (@(posedge clk_in) disable iff (rst_any)
        (!$past(rst_any) && !$past(rst_any, 2) && !held_q) |-> (clk_out != $past(clk_out)));
    end
  endgenerate
endmodule

// File: tb/frac_edge_clk_div_bench.sv
module frac_edge_clk_div_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, chip_rst, align_in;
  logic out_a, out_b;

  frac_edge_clk_div u_frac_edge_clk_div (
    .clk_in(clk), .rst(rst), .chip_rst(chip_rst), .align_in(align_in), .clk_out(out_a)
  );

  frac_edge_clk_div #(.DIV_HALVES(7), .USE_CHIP_RST(1'b1)) u_frac_edge_clk_div_d35 (
    .clk_in(clk), .rst(rst), .chip_rst(chip_rst), .align_in(align_in), .clk_out(out_b)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R3 R8";

  int halves [2] = '{4, 7};
  int ph     [2];
  int lvl_r  [2];
  int lvl_f  [2];
  int hist   [2][3];

  function automatic bit in_reset(input int i);
    return rst || (i == 1 && chip_rst);
  endfunction

  task automatic model_edge(input int i);
    int hi;
    bit slip;
    hi = (halves[i] + 1) / 2;
    if (in_reset(i)) begin
      ph[i] = halves[i] - 2;
      lvl_r[i] = 0; lvl_f[i] = 0;
      for (int k = 0; k < 3; k++) hist[i][k] = 0;
    end else begin
      slip = (hist[i][1] == 1) && (hist[i][2] == 0);
      if (slip) begin
        lvl_r[i] = lvl_f[i];
      end else begin
        ph[i] = (ph[i] + 2) % halves[i];
        lvl_r[i] = (ph[i] < hi) ? 1 : 0;
        lvl_f[i] = (((ph[i] + 1) % halves[i]) < hi) ? 1 : 0;
      end
      hist[i][2] = hist[i][1];
      hist[i][1] = hist[i][0];
      hist[i][0] = align_in ? 1 : 0;
    end
  endtask

  task automatic check_half(input bit fall_half);
    for (int i = 0; i < 2; i++) begin
      int exp_v, got_v;
      exp_v = in_reset(i) ? 0 : (fall_half ? lvl_f[i] : lvl_r[i]);
      got_v = (i == 0) ? int'(out_a) : int'(out_b);
      n_chk++;
      if (got_v != exp_v) begin
        n_bad++;
        $display("FAIL %s inst=%0d half=%0d t=%0t got=%0d exp=%0d",
                 tag, i, fall_half, $time, got_v, exp_v);
      end
    end
  endtask

  // Reference model and comparison, twice per input cycle away from edges.
  initial begin
    forever begin
      @(posedge clk);
      model_edge(0);
      model_edge(1);
      #2 check_half(1'b0);
      @(negedge clk);
      #2 check_half(1'b1);
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
  endtask

  initial begin
    rst = 1'b1; chip_rst = 1'b0; align_in = 1'b0;
    cyc(3);
    #3 rst = 1'b0;
    tag = "R1 R2 R4 R8";
    cyc(24);

    tag = "R5 R6";
    for (int off = 0; off < 7; off++) begin
      #3 align_in = 1'b1;
      cyc(1);
      #3 align_in = 1'b0;
      cyc(6 + off);
    end
    #3 align_in = 1'b1;
    cyc(20);
    #3 align_in = 1'b0;
    cyc(12);

    tag = "R3";
    #1 rst = 1'b1;
    cyc(2);
    #3 rst = 1'b0;
    tag = "R4";
    cyc(16);

    tag = "R7";
    #1 chip_rst = 1'b1;
    cyc(2);
    #3 chip_rst = 1'b0;
    cyc(16);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog %s got=hung exp=finished", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule